// File: doc/BRIEF.md
# Transmit PLL Bring-Up Reset Sequencer

This block brings a bonded group of transmit-only serial channels out of reset after power-on or after a system reset. It first keeps the transmit PLL powered down for a fixed minimum time. It then lets the PLL start up and waits until the PLL reports a steady lock. Only after that does it release the datapath reset shared by all channels of the group. The transmit datapath reset stays asserted for the whole of that sequence.

The lock status comes from the analog PLL and is asynchronous to the clock, so it is synchronized first. It must then stay high for a set number of consecutive cycles before it is trusted. If lock is lost while the channels are running, the datapath reset is re-asserted at once and the sequencer waits for lock again. If lock does not arrive within a timeout window, the sequencer powers the PLL down again and restarts the whole sequence. A ready flag tells the user logic when the channels may send data.

Top module: `txrst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pll_pd_out` is 1, every bit of `txd_rst` is 1 and `tx_ready` is 0. An assertion of `rst_n` in any state returns the block to this state.
- R2: After `rst_n` rises, `pll_pd_out` stays high for exactly PD = ceil(CLK_FREQ_HZ / 1e6) + PD_MARGIN_CYCLES rising clock edges, which is at least one microsecond. It falls after edge PD.
- R3: Whenever `pll_pd_out` is high, every bit of `txd_rst` is high.
- R4: Once `pll_pd_out` is low and `pll_lock_in` rises and then stays high, `txd_rst` falls after exactly LOCK_STABLE_CYCLES + 3 rising edges. This is two synchronizer stages, the stability count, and the output register.
- R5: A lock pulse that lasts fewer than LOCK_STABLE_CYCLES consecutive sampled cycles does not release `txd_rst`, and `tx_ready` stays 0.
- R6: When `pll_lock_in` falls while the block is running, `txd_rst` returns to all ones and `tx_ready` to 0 after exactly 3 rising edges. `pll_pd_out` stays low. A later steady lock releases the reset again with the R4 latency.
- R7: If no steady lock is seen within TIMEOUT_CYCLES edges of entering the lock wait, `pll_pd_out` rises again. This happens 3 + TIMEOUT_CYCLES edges after a lock loss in the running state. The full R2 power-down hold then repeats.
- R8: `tx_ready` is 1 exactly when `txd_rst` is all zeros, and never while `pll_pd_out` is high.
- R9: All NUM_CH bits of `txd_rst` always carry the same value, one registered copy per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, CLK_FREQ_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_lock_in | input | 1 | Asynchronous PLL lock status |
| pll_pd_out | output | 1 | PLL power-down, active high, registered |
| txd_rst | output | NUM_CH | Per-channel transmit datapath reset, active high, registered |
| tx_ready | output | 1 | High while the channels may send data |

## Verification
The bench builds the block with CLK_FREQ_HZ = 50 MHz and PD_MARGIN_CYCLES = 3, which gives a 53-cycle power-down hold. It sets LOCK_STABLE_CYCLES = 8 and TIMEOUT_CYCLES = 200. These small values keep each power-down hold and each lock-wait timeout only a few hundred cycles long. The bench can therefore drive many lock losses, sub-threshold lock glitches of random length, and a full timeout-driven restart, each followed by a fresh power-down hold, within one short run. With four channels, the per-channel copies of the reset can also be compared against one another.

// File: rtl/txrst_pkg.sv
// Shared types and helpers for the transmit reset sequencer.
// Assumes the clock frequency is given in Hz and fits in 32 bits.
package txrst_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SEQ_PWRDN = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    // Cycles needed to cover one microsecond at the given clock, rounded up
    function automatic int unsigned cycles_per_us(input int unsigned freq_hz);
        longint unsigned f;
        f = longint'(freq_hz);
        return int'((f + 64'd999_999) / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/txrst_sync.sv
// Multi-stage synchronizer for a single asynchronous level.
// Assumes the input is a slow level signal; the output resets to 0.
module txrst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/txrst_lock_filter.sv
// Lock qualifier: reports a good lock only after the synchronized lock
// level has been high for STABLE_CYCLES consecutive cycles.
// Any low cycle restarts the count from zero.
module txrst_lock_filter #(
    parameter int unsigned STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    output logic lock_good
);
    localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] FULL = CW'(STABLE_CYCLES);

    logic [CW-1:0] run_q;

    // Count consecutive high cycles, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (!lock_s)      run_q <= '0;
        else if (run_q != FULL) run_q <= run_q + 1'b1;
    end

    assign lock_good = (run_q == FULL);
endmodule

// File: rtl/txrst_ctrl.sv
// Phase controller: power-down hold, lock wait with timeout, running.
// Outputs are derived from the next phase so that the registered copies
// change in the same edge as the phase. The datapath reset is exported as
// its next value so the top can register one copy per channel.
module txrst_ctrl
    import txrst_pkg::*;
#(
    parameter int unsigned PD_CYCLES      = 250,
    parameter int unsigned TIMEOUT_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    input  logic lock_good,
    output logic pd_q,
    output logic ready_q,
    output logic txrst_d
);
    localparam int unsigned PW = $clog2(PD_CYCLES + 1);
    localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [PW-1:0] PD_LAST = PW'(PD_CYCLES - 1);
    localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYCLES - 1);

    seq_state_e    state_q, state_d;
    logic [PW-1:0] pd_cnt_q;
    logic [TW-1:0] to_cnt_q;

    // Next-phase decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_PWRDN: if (pd_cnt_q == PD_LAST) state_d = SEQ_WAIT;
            SEQ_WAIT: begin
                if (lock_good)                state_d = SEQ_RUN;
                else if (to_cnt_q == TO_LAST) state_d = SEQ_PWRDN;
            end
            SEQ_RUN:   if (!lock_s) state_d = SEQ_WAIT;
            default:   state_d = SEQ_PWRDN;
        endcase
    end

    // Phase register and the phase timers, cleared on every phase change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_PWRDN;
            pd_cnt_q <= '0;
            to_cnt_q <= '0;
        end else begin
            state_q  <= state_d;
            pd_cnt_q <= (state_q == SEQ_PWRDN && state_d == SEQ_PWRDN) ? pd_cnt_q + 1'b1 : '0;
            to_cnt_q <= (state_q == SEQ_WAIT  && state_d == SEQ_WAIT)  ? to_cnt_q + 1'b1 : '0;
        end
    end

    // Registered power-down and ready flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q    <= 1'b1;
            ready_q <= 1'b0;
        end else begin
            pd_q    <= (state_d == SEQ_PWRDN);
            ready_q <= (state_d == SEQ_RUN);
        end
    end

    assign txrst_d = (state_d != SEQ_RUN);
endmodule

// File: rtl/txrst_seq.sv
// Transmit reset sequencer for a bonded group of NUM_CH transmit channels.
// Holds the PLL powered down for at least 1 us plus a margin, waits for a
// qualified lock, then releases the shared datapath reset. Assumes clk is
// free-running at CLK_FREQ_HZ and pll_lock_in is asynchronous.
module txrst_seq
    import txrst_pkg::*;
#(
    parameter int unsigned NUM_CH             = 4,
    parameter int unsigned CLK_FREQ_HZ        = 250_000_000,
    parameter int unsigned PD_MARGIN_CYCLES   = 0,
    parameter int unsigned LOCK_STABLE_CYCLES = 16,
    parameter int unsigned TIMEOUT_CYCLES     = 2000,
    parameter int unsigned SYNC_STAGES        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock_in,
    output logic              pll_pd_out,
    output logic [NUM_CH-1:0] txd_rst,
    output logic              tx_ready
);
    localparam int unsigned PD_CYCLES = cycles_per_us(CLK_FREQ_HZ) + PD_MARGIN_CYCLES;

    logic lock_s;
    logic lock_good;
    logic txrst_d;

    txrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pll_lock_in),
        .sync_out (lock_s)
    );

    txrst_lock_filter #(.STABLE_CYCLES(LOCK_STABLE_CYCLES)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_s    (lock_s),
        .lock_good (lock_good)
    );

    txrst_ctrl #(
        .PD_CYCLES      (PD_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_s    (lock_s),
        .lock_good (lock_good),
        .pd_q      (pll_pd_out),
        .ready_q   (tx_ready),
        .txrst_d   (txrst_d)
    );

    // One registered reset copy per channel, placed near each channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) txd_rst[ch] <= 1'b1;
            else        txd_rst[ch] <= txrst_d;
        end
    end
endmodule

// File: rtl/txrst_seq_chk.sv
// Property checker for txrst_seq, attached by bind. Uses only the top's
// ports; window lengths are tracked with counters, not deep $past.
module txrst_seq_chk #(
    parameter int unsigned NUM_CH             = 4,
    parameter int unsigned PD_CYCLES          = 250,
    parameter int unsigned LOCK_STABLE_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_lock_in,
    input logic              pll_pd_out,
    input logic [NUM_CH-1:0] txd_rst,
    input logic              tx_ready
);
    int unsigned pd_run_q;
    int unsigned lock_run_q;

    // Length of the current power-down run
    always_ff @(posedge clk) begin
        if (!rst_n)          pd_run_q <= 0;
        else if (!pll_pd_out) pd_run_q <= 0;
        else if (pd_run_q < PD_CYCLES) pd_run_q <= pd_run_q + 1;
    end

    // Length of the current run of high lock samples
    always_ff @(posedge clk) begin
        if (!rst_n)            lock_run_q <= 0;
        else if (!pll_lock_in) lock_run_q <= 0;
        else if (lock_run_q < LOCK_STABLE_CYCLES) lock_run_q <= lock_run_q + 1;
    end

    // R2
    pd_hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_pd_out) |-> pd_run_q >= PD_CYCLES);

    // R3
    pd_keeps_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_pd_out |-> (&txd_rst));

    // R5
    lock_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> lock_run_q >= LOCK_STABLE_CYCLES);

    // R6
    loss_keeps_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> !pll_pd_out);

    // R8
    ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready == ((txd_rst == '0) && !pll_pd_out));

    // R9
    ch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_rst == '0) || (&txd_rst));
endmodule

bind txrst_seq txrst_seq_chk #(
    .NUM_CH             (NUM_CH),
    .PD_CYCLES          (PD_CYCLES),
    .LOCK_STABLE_CYCLES (LOCK_STABLE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_lock_in (pll_lock_in),
    .pll_pd_out  (pll_pd_out),
    .txd_rst     (txd_rst),
    .tx_ready    (tx_ready)
);

// File: tb/txrst_seq_test.sv
module txrst_seq_test;
    localparam int unsigned NUM_CH   = 4;
    localparam int unsigned FREQ     = 50_000_000;
    localparam int unsigned MARGIN   = 3;
    localparam int unsigned STABLE   = 8;
    localparam int unsigned TIMEOUT  = 200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lock = 1'b0;
    logic              pd;
    logic [NUM_CH-1:0] trst;
    logic              rdy;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    txrst_seq #(
        .NUM_CH(NUM_CH), .CLK_FREQ_HZ(FREQ), .PD_MARGIN_CYCLES(MARGIN),
        .LOCK_STABLE_CYCLES(STABLE), .TIMEOUT_CYCLES(TIMEOUT), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pll_lock_in(lock),
        .pll_pd_out(pd), .txd_rst(trst), .tx_ready(rdy)
    );

    // Expected values from the requirements
    function automatic int exp_pd();
        return (FREQ + 999_999) / 1_000_000 + MARGIN;
    endfunction
    function automatic int exp_release();
        return STABLE + 3;
    endfunction
    function automatic int exp_loss();
        return 3;
    endfunction
    function automatic int exp_timeout();
        return 3 + TIMEOUT;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sel: 0 pd falls, 1 pd rises, 2 trst all zero, 3 trst all ones
    function automatic bit cond(input int sel);
        case (sel)
            0: return pd == 1'b0;
            1: return pd == 1'b1;
            2: return trst == '0;
            default: return &trst;
        endcase
    endfunction

    task automatic edges_until(input int sel, input int limit, output int n, output bit pd_rst_ok);
        n = 0;
        pd_rst_ok = 1;
        while (n < limit) begin
            @(posedge clk);
            #1;
            n++;
            if (pd && !(&trst)) pd_rst_ok = 0;
            if (cond(sel)) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (4) @(negedge clk);
        check(pd == 1 && (&trst) && rdy == 0, "R1 in reset", {pd, rdy}, 2);
        rst_n = 1;
    endtask

    task automatic measure_pd(input string tag);
        int n; bit ok;
        edges_until(0, 1000, n, ok);
        check(n == exp_pd(), {tag, " R2 hold"}, n, exp_pd());
        check(ok, {tag, " R3 reset during pd"}, ok, 1);
    endtask

    task automatic bring_lock(input string tag);
        int n; bit ok;
        @(negedge clk);
        lock = 1;
        edges_until(2, 1000, n, ok);
        check(n == exp_release(), {tag, " R4 release"}, n, exp_release());
        check(rdy == 1 && pd == 0, {tag, " R8 ready"}, {rdy, pd}, 2);
        check(trst == '0, {tag, " R9 channels"}, trst, 0);
    endtask

    initial begin
        int n; bit ok;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(pd == 1 && (&trst) && rdy == 0, "R1 initial", {pd, rdy}, 2);
        do_reset();
        @(posedge clk); #1;
        check(pd == 1 && (&trst) && rdy == 0, "R1 first cycle", {pd, rdy}, 2);
        // first edge already consumed: remaining pd edges
        edges_until(0, 1000, n, ok);
        check(n + 1 == exp_pd(), "R2 hold after reset", n + 1, exp_pd());
        check(ok, "R3 reset during pd", ok, 1);
        bring_lock("initial");

        for (int it = 0; it < 6; it++) begin
            int g;
            repeat ($urandom_range(1, 20)) @(negedge clk);
            lock = 0;
            edges_until(3, 100, n, ok);
            check(n == exp_loss(), "R6 loss latency", n, exp_loss());
            check(pd == 0 && rdy == 0, "R6 pll stays up", {pd, rdy}, 0);
            g = $urandom_range(1, STABLE - 1);
            @(negedge clk);
            lock = 1;
            repeat (g) @(negedge clk);
            lock = 0;
            repeat (12) @(negedge clk);
            check((&trst) && rdy == 0, "R5 short glitch", g, 0);
            bring_lock("relock R6");
        end

        // Corner: glitch one below the threshold, exactly
        @(negedge clk);
        lock = 0;
        repeat (5) @(negedge clk);
        lock = 1;
        repeat (STABLE - 1) @(negedge clk);
        lock = 0;
        repeat (12) @(negedge clk);
        check((&trst) && rdy == 0, "R5 threshold-1 glitch", rdy, 0);
        bring_lock("after edge glitch");

        // Timeout restart
        @(negedge clk);
        lock = 0;
        edges_until(1, 1000, n, ok);
        check(n == exp_timeout(), "R7 timeout", n, exp_timeout());
        check((&trst) && rdy == 0, "R7 reset on restart", rdy, 0);
        measure_pd("restart");
        bring_lock("after timeout");

        // Reset in the running state
        do_reset();
        @(posedge clk); #1;
        check(pd == 1 && (&trst) && rdy == 0, "R1 reset from run", {pd, rdy}, 2);
        lock = 0;
        edges_until(0, 1000, n, ok);
        check(n + 1 == exp_pd(), "R2 hold after run reset", n + 1, exp_pd());
        bring_lock("final");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule